// File: doc/BRIEF.md
# Two-Section Ripple-Style Decade Counter

The block holds two counting sections that share nothing but their control inputs. Section A is a single toggle bit driven by count input `cnt_a`. Section B is a three-bit counter driven by count input `cnt_b`. Parameter `MOD_B` sets the length of its cycle to 5, 6 or 8. Both sections advance on the falling edge of their own count input. Those edges come from synchronising the inputs to the system clock `clk` and comparing each synchronised level with its value one cycle earlier. The whole design runs in one clock domain.

Chaining is done outside the block.

- **A then B:** tie `q_a` to `cnt_b` and apply pulses to `cnt_a`. The four outputs then read a BCD decade (`MOD_B=5`), a count modulo twelve (`MOD_B=6`) or a four-bit binary count (`MOD_B=8`).
- **B then A, five-state build only:** tie `q_d` to `cnt_a` and apply pulses to `cnt_b`. Output `q_a` then carries a square wave at one tenth of the input rate, with equal high and low times.

Two gated controls override counting. Each is active only while both of its inputs are high.

- The zero pair clears every output.
- In the five-state build, the nine pair loads the value nine. Nine is used for nine's-complement arithmetic.
- Zero wins over nine.

Top module: `dual_section_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all four outputs are 0 after that edge.
- R2: While both zero inputs are high, the outputs read 0000. They stay at 0000 and ignore every count edge until the pair is released.
- R3: When only one input of a gated pair is high, the pair has no effect. Counting proceeds and the outputs keep their value.
- R4: When the zero pair and the nine pair are active together, the outputs read 0000.
- R5: With `MOD_B=5`, the nine pair active (and zero inactive) loads q_d,q_c,q_b,q_a = 1,0,0,1. The next `cnt_a` falling edge in chained mode then gives 0000.
- R6: With `MOD_B` equal to 6 or 8, the nine pair has no effect on the outputs.
- R7: Each falling edge of `cnt_a` inverts `q_a` when no gated control is active.
- R8: Each falling edge of `cnt_b` advances the value {q_d,q_c,q_b} by one, modulo `MOD_B`. This value is never `MOD_B` or above.
- R9: In A-then-B chaining, after n falling edges on `cnt_a` from zero, the nibble {q_d,q_c,q_b,q_a} equals n modulo (2*`MOD_B`).
- R10: In B-then-A chaining with `MOD_B=5`, after k falling edges on `cnt_b` from zero, {q_d,q_c,q_b} = k mod 5 and `q_a` = (k/5) mod 2. Over twenty edges `q_a` is high after exactly ten of them.
- R11: Rising edges and steady levels on a count input do not change the outputs. Each input falling edge changes the outputs exactly `SYNC_STAGES`+1 clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_a | input | 1 | Count input of section A (falling edge counts) |
| cnt_b | input | 1 | Count input of section B (falling edge counts) |
| zero_x | input | 1 | First input of the gated clear-to-zero pair |
| zero_y | input | 1 | Second input of the gated clear-to-zero pair |
| nine_x | input | 1 | First input of the gated load-nine pair |
| nine_y | input | 1 | Second input of the gated load-nine pair |
| q_a | output | 1 | Section A bit |
| q_b | output | 1 | Section B bit 0 |
| q_c | output | 1 | Section B bit 1 |
| q_d | output | 1 | Section B bit 2 |

## Verification
The assertions assume that every count and control input holds each level for at least two system-clock cycles. This lets the synchroniser deliver each edge as a single enable without losing or merging edges. The bench meets this assumption by keeping each level for eight cycles. Where an output is fed back to a count input, the bench also waits long enough for the section-to-section delay to settle before sampling. When the chaining is changed, the stray edge that the switch produces could break this assumption. The bench therefore makes every such switch while the zero pair is held active, so the stray edge is absorbed by the clear.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int QB_W = 3;

  typedef enum logic [1:0] {
    CTL_COUNT = 2'd0,
    CTL_NINE  = 2'd1,
    CTL_ZERO  = 2'd2
  } ctl_e;

  // zero overrides nine, both override counting
  function automatic ctl_e ctl_pick(input logic zero_hit, input logic nine_hit);
    if (zero_hit) return CTL_ZERO;
    if (nine_hit) return CTL_NINE;
    return CTL_COUNT;
  endfunction
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/dsc_edge.sv
module dsc_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] cur;
  logic [WIDTH-1:0] prev;

  dsc_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (din),
    .lvl (cur)
  );

  // prev resets low so a line already high at reset release is not a fall
  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= cur;
  end

  assign fall = prev & ~cur;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (fall != '0) |=> ((fall & $past(fall)) == '0)); // R11
endmodule

// File: rtl/dsc_div2.sv
module dsc_div2
  import dsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_e ctl,
  input  logic tick,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      case (ctl)
        CTL_ZERO: q <= 1'b0;
        CTL_NINE: q <= 1'b1;
        default:  if (tick) q <= ~q;
      endcase
    end
  end

  AST_A_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (ctl == CTL_COUNT && tick) |=> (q != $past(q))); // R7
  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl == CTL_COUNT && !tick) |=> $stable(q)); // R11
endmodule

// File: rtl/dsc_divn.sv
module dsc_divn
  import dsc_pkg::*;
#(
  parameter int MOD = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  ctl_e            ctl,
  input  logic            tick,
  output logic [QB_W-1:0] q
);
  localparam int             W         = QB_W;
  localparam logic [W-1:0]   LAST      = W'(MOD - 1);
  localparam logic [W-1:0]   NINE_CODE = W'(4);

  logic [W-1:0] nxt;

  generate
    if (MOD == (1 << W)) begin : g_pow2
      assign nxt = q + 1'b1;
    end else begin : g_wrap
      assign nxt = (q == LAST) ? '0 : q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else begin
      case (ctl)
        CTL_ZERO: q <= '0;
        CTL_NINE: q <= NINE_CODE;
        default:  if (tick) q <= nxt;
      endcase
    end
  end

  AST_B_RANGE: assert property (@(posedge clk) disable iff (rst)
    q <= LAST); // R8
  AST_B_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctl == CTL_COUNT && tick) |=>
      (q == (($past(q) == LAST) ? '0 : W'($past(q) + 1'b1)))); // R8
  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl == CTL_COUNT && !tick) |=> $stable(q)); // R11
endmodule

// File: rtl/dual_section_counter.sv
module dual_section_counter
  import dsc_pkg::*;
#(
  parameter int MOD_B       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cnt_a,
  input  logic cnt_b,
  input  logic zero_x,
  input  logic zero_y,
  input  logic nine_x,
  input  logic nine_y,
  output logic q_a,
  output logic q_b,
  output logic q_c,
  output logic q_d
);
  localparam bit NINE_ON = (MOD_B == 5);
  localparam int N_CTL   = 4;
  localparam int N_CNT   = 2;

  logic [N_CTL-1:0]  ctl_lvl;
  logic [N_CNT-1:0]  cnt_fall;
  logic              zero_hit, nine_hit;
  ctl_e              ctl;
  logic              a_q;
  logic [QB_W-1:0]   b_q;

  dsc_sync #(.WIDTH(N_CTL), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .din ({nine_y, nine_x, zero_y, zero_x}),
    .lvl (ctl_lvl)
  );

  dsc_edge #(.WIDTH(N_CNT), .STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({cnt_b, cnt_a}),
    .fall (cnt_fall)
  );

  assign zero_hit = ctl_lvl[0] & ctl_lvl[1];
  assign nine_hit = NINE_ON & ctl_lvl[2] & ctl_lvl[3];
  assign ctl      = ctl_pick(zero_hit, nine_hit);

  dsc_div2 u_sec_a (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .tick (cnt_fall[0]),
    .q    (a_q)
  );

  dsc_divn #(.MOD(MOD_B)) u_sec_b (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .tick (cnt_fall[1]),
    .q    (b_q)
  );

  assign q_a = a_q;
  assign q_b = b_q[0];
  assign q_c = b_q[1];
  assign q_d = b_q[2];

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> ({q_d, q_c, q_b, q_a} == 4'd0)); // R1
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctl_lvl[0] && ctl_lvl[1]) |=> ({q_d, q_c, q_b, q_a} == 4'd0)); // R2
  AST_CLEAR_BEATS_NINE: assert property (@(posedge clk) disable iff (rst)
    (ctl_lvl[0] && ctl_lvl[1] && ctl_lvl[2] && ctl_lvl[3])
      |=> ({q_d, q_c, q_b, q_a} == 4'd0)); // R4
  AST_NINE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (NINE_ON && ctl_lvl[2] && ctl_lvl[3] && !(ctl_lvl[0] && ctl_lvl[1]))
      |=> ({q_d, q_c, q_b, q_a} == 4'b1001)); // R5
  AST_NINE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!NINE_ON && ctl_lvl[2] && ctl_lvl[3] && !(ctl_lvl[0] && ctl_lvl[1])
      && cnt_fall == '0) |=> $stable({q_d, q_c, q_b, q_a})); // R6
endmodule

// File: tb/sim_dual_section_counter.sv
`timescale 1ns/1ps
module sim_dual_section_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic drv_a = 1'b1, drv_b = 1'b1;
  logic zx = 1'b0, zy = 1'b0, nx = 1'b0, ny = 1'b0;
  logic bq = 1'b0;
  int checks = 0, failures = 0;
  int e0 = 0, e1 = 0, e2 = 0;

  logic qa0, qb0, qc0, qd0, qa1, qb1, qc1, qd1, qa2, qb2, qc2, qd2;
  logic a0_in, b0_in;
  assign a0_in = bq ? qd0 : drv_a;
  assign b0_in = bq ? drv_b : qa0;

  dual_section_counter #(.MOD_B(5)) u0 (
    .clk(clk), .rst(rst), .cnt_a(a0_in), .cnt_b(b0_in),
    .zero_x(zx), .zero_y(zy), .nine_x(nx), .nine_y(ny),
    .q_a(qa0), .q_b(qb0), .q_c(qc0), .q_d(qd0));
  dual_section_counter #(.MOD_B(6)) u1 (
    .clk(clk), .rst(rst), .cnt_a(drv_a), .cnt_b(qa1),
    .zero_x(zx), .zero_y(zy), .nine_x(nx), .nine_y(ny),
    .q_a(qa1), .q_b(qb1), .q_c(qc1), .q_d(qd1));
  dual_section_counter #(.MOD_B(8)) u2 (
    .clk(clk), .rst(rst), .cnt_a(drv_a), .cnt_b(qa2),
    .zero_x(zx), .zero_y(zy), .nine_x(nx), .nine_y(ny),
    .q_a(qa2), .q_b(qb2), .q_c(qc2), .q_d(qd2));

  logic [3:0] n0, n1, n2;
  assign n0 = {qd0, qc0, qb0, qa0};
  assign n1 = {qd1, qc1, qb1, qa1};
  assign n2 = {qd2, qc2, qb2, qa2};

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " mod5"}, int'(n0), e0);
    chk({req, " mod6"}, int'(n1), e1);
    chk({req, " mod8"}, int'(n2), e2);
  endtask

  task automatic pulse_a;
    drv_a = 1'b0; wait_cyc(8);
    drv_a = 1'b1; wait_cyc(8);
    e0 = (e0 + 1) % 10; e1 = (e1 + 1) % 12; e2 = (e2 + 1) % 16;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int highs;
    wait_cyc(4);
    chk_all("R1 reset");
    rst = 1'b0;
    wait_cyc(8);
    chk_all("R11 idle after reset");

    // A-then-B chaining sweep over more than a full cycle of every build
    for (int n = 1; n <= 20; n++) begin
      pulse_a();
      chk_all("R9 R7 R8 chained");
    end

    // single inputs of a pair do nothing (e0=0, e1=8, e2=4)
    zx = 1'b1; wait_cyc(8); chk_all("R3 zero_x alone");
    pulse_a(); chk_all("R3 count with zero_x alone");
    zx = 1'b0; zy = 1'b1; wait_cyc(8); chk_all("R3 zero_y alone");
    zy = 1'b0; nx = 1'b1; wait_cyc(8); chk_all("R3 nine_x alone");
    nx = 1'b0; ny = 1'b1; wait_cyc(8); chk_all("R3 nine_y alone");
    ny = 1'b0; wait_cyc(8);

    // load nine
    nx = 1'b1; ny = 1'b1; wait_cyc(8);
    e0 = 9;
    chk("R5 nine load", int'(n0), 9);
    chk("R6 nine ignored mod6", int'(n1), e1);
    chk("R6 nine ignored mod8", int'(n2), e2);
    nx = 1'b0; ny = 1'b0; wait_cyc(8);
    pulse_a();
    chk("R5 nine then count", int'(n0), 0);
    chk("R6 count after nine mod6", int'(n1), e1);
    chk("R6 count after nine mod8", int'(n2), e2);

    // clear, and clear against nine
    pulse_a(); pulse_a(); pulse_a();
    chk_all("R9 nonzero before clear");
    zx = 1'b1; zy = 1'b1; nx = 1'b1; ny = 1'b1; wait_cyc(8);
    e0 = 0; e1 = 0; e2 = 0;
    chk_all("R4 clear beats nine");
    nx = 1'b0; ny = 1'b0;
    drv_a = 1'b0; wait_cyc(8); drv_a = 1'b1; wait_cyc(8);
    chk_all("R2 clear holds against count");

    // switch to B-then-A chaining under clear
    bq = 1'b1; wait_cyc(8);
    zx = 1'b0; zy = 1'b0; wait_cyc(8);
    chk_all("R2 released clear");

    highs = 0;
    for (int k = 1; k <= 20; k++) begin
      drv_b = 1'b0; wait_cyc(8);
      drv_b = 1'b1; wait_cyc(8);
      chk("R10 biquinary", int'(n0), (k % 5) * 2 + ((k / 5) % 2));
      if (qa0) highs++;
    end
    chk("R10 duty high count", highs, 10);
    chk("R11 mod6 idle during biquinary", int'(n1), e1);
    chk("R11 mod8 idle during biquinary", int'(n2), e2);

    summary();
    $finish;
  end
endmodule